// File: doc/BRIEF.md
# Burst-of-Four Quad-Data-Rate SRAM Core

This block is a synchronous memory with two data paths: one input path used only for writes and one output path used only for reads. The two paths never share wires, so a write and a read can be in progress together and the bus never has to turn around. One address bus serves both ports. Its owner changes on every clock: a read slot is followed by a write slot, then by a read slot again, and the first slot after reset is a read slot. Each address names a burst of four 18-bit words. The double-data-rate transfer is modelled at one transfer per clock, so every cycle moves a 36-bit pair of words and a burst takes two cycles on either port.

A write is launched by pulling the write select low in a write slot. That cycle carries words 0 and 1 with their byte-lane enables, and the next cycle carries words 2 and 3. A read is launched by pulling the read select low in a read slot. Words 0 and 1 then come out two cycles later and words 2 and 3 the cycle after that, with a valid flag marking both beats. The address width is a parameter and should be kept small in simulation. Reset puts the slot back to read and empties the pipelines, but it leaves the stored data alone.

Top module: `qdr_burst4_sram`

## Requirements
- R1: While reset is held and after it is released, `rvalid` is 0 and `rdata` is 0 until a read is launched. The first clock edge after reset is released is a read slot, and a read select asserted for that edge is honoured.
- R2: Slots alternate read, write, read, and so on. A low `rd_sel_n` at a write-slot edge launches no read, and `rvalid` stays low as a result. A low `wr_sel_n` at a read-slot edge changes no stored word.
- R3: At the write-slot edge with `wr_sel_n` low, the block takes `wdata` as words 0 (bits 17:0) and 1 (bits 35:18) of the burst at `addr`. At the following edge it takes `wdata` as words 2 (bits 17:0) and 3 (bits 35:18).
- R4: `wbe_n[i]` is an active-low enable for `wdata[9*i+8:9*i]` in each write beat. A 9-bit lane whose enable is high keeps its previous content.
- R5: Call E the read-slot edge at which the read was captured. Words 0 and 1 appear on `rdata` (word 0 in bits 17:0) after edge E+2. Words 2 and 3 appear after edge E+3. `rvalid` is high in exactly those two cycles.
- R6: Reads issued in consecutive read slots produce an unbroken stream on `rdata`, with `rvalid` held high across bursts. Writes to other addresses in the write slots in between do not disturb that stream.
- R7: Suppose a write to the same address is captured in the write slot right after a read. The read then returns the new data in every lane that write enables and the old data in every other lane.
- R8: A read captured in the slot right after a write to the same address returns the newly written words.
- R9: Reset returns the slot to read and clears the pipeline valid flags. Words already written before reset are still returned afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read launch, honoured in read slots only |
| wr_sel_n | input | 1 | Active-low write launch, honoured in write slots only |
| addr | input | ADDR_W | Shared burst address |
| wdata | input | 2*WORD_W | Write word pair for the current beat |
| wbe_n | input | 2*WORD_W/BYTE_W | Active-low 9-bit lane enables for `wdata` |
| rdata | output | 2*WORD_W | Read word pair |
| rvalid | output | 1 | High while `rdata` carries a read beat |

## Verification
Every result has a fixed due cycle. Counting from the capture edge, a write's first pair is stored at edge +1 and its second pair at edge +2. A read's pairs are due after edges +2 and +3. A cycle-accurate reference model in the bench keeps a schedule of pending stores and due read beats. At each edge it applies the stores due at that edge before it works out the read beat due at that edge, which also makes the forwarding case in R7 come out right. The outputs are compared against the model at the falling edge of every cycle, so `rvalid` is checked in every cycle and `rdata` whenever a beat is due.

// File: rtl/qdr_burst_pkg.sv
package qdr_burst_pkg;
   typedef enum logic {
      SLOT_RD = 1'b0,
      SLOT_WR = 1'b1
   } slot_e;
endpackage

// File: rtl/qdr_slot_phase.sv
module qdr_slot_phase
   import qdr_burst_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   output slot_e slot
);
   // Ownership of the shared address bus flips every edge; reset returns it to read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= SLOT_RD;
      else        slot <= (slot == SLOT_RD) ? SLOT_WR : SLOT_RD;
   end
endmodule

// File: rtl/qdr_write_path.sv
module qdr_write_path
   import qdr_burst_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int PAIR_W = 36,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slot_e             slot,
   input  logic              wr_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [PAIR_W-1:0] wdata,
   input  logic [LANES-1:0]  wbe_n,
   output logic              cm_vld,
   output logic [ADDR_W:0]   cm_idx,
   output logic [PAIR_W-1:0] cm_data,
   output logic [LANES-1:0]  cm_be
);
   logic              tail_due;
   logic [ADDR_W-1:0] tail_addr;
   logic              launch;

   assign launch = (slot == SLOT_WR) && !wr_sel_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cm_vld   <= 1'b0;
         tail_due <= 1'b0;
      end else begin
         cm_vld   <= tail_due || launch;
         tail_due <= !tail_due && launch;
      end
   end

   // Staged beat: words 0/1 at the launch edge, words 2/3 one edge later.
   always_ff @(posedge clk) begin
      cm_data <= wdata;
      cm_be   <= ~wbe_n;
      if (tail_due) begin
         cm_idx <= {tail_addr, 1'b1};
      end else if (launch) begin
         cm_idx    <= {addr, 1'b0};
         tail_addr <= addr;
      end
   end

   assert_wr_second_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_vld && !cm_idx[0]) |=> (cm_vld && cm_idx[0] &&
                                  cm_idx[ADDR_W:1] == $past(cm_idx[ADDR_W:1])));

   assert_wr_slot_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_vld && !cm_idx[0]) |-> ($past(slot) == SLOT_WR));
endmodule

// File: rtl/qdr_pair_array.sv
module qdr_pair_array #(
   parameter int IDX_W  = 7,
   parameter int PAIR_W = 36,
   parameter int BYTE_W = 9
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [PAIR_W-1:0] wdata,
   input  logic [PAIR_W/BYTE_W-1:0] wbe,
   input  logic [IDX_W-1:0]  ridx,
   output logic [PAIR_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int LANES = PAIR_W / BYTE_W;

   // One storage column per 9-bit lane; contents are never reset.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] col [DEPTH];
      always_ff @(posedge clk) begin
         if (we && wbe[l]) col[widx] <= wdata[l*BYTE_W +: BYTE_W];
      end
      assign rdata[l*BYTE_W +: BYTE_W] = col[ridx];
   end
endmodule

// File: rtl/qdr_read_path.sv
module qdr_read_path
   import qdr_burst_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int PAIR_W = 36,
   parameter int BYTE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  slot_e             slot,
   input  logic              rd_sel_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cm_vld,
   input  logic [ADDR_W:0]   cm_idx,
   input  logic [PAIR_W-1:0] cm_data,
   input  logic [PAIR_W/BYTE_W-1:0] cm_be,
   input  logic [PAIR_W-1:0] arr_rdata,
   output logic [ADDR_W:0]   arr_ridx,
   output logic [PAIR_W-1:0] rdata,
   output logic              rvalid
);
   localparam int LANES = PAIR_W / BYTE_W;

   logic              q_vld, q_beat;
   logic [ADDR_W-1:0] q_addr;
   logic              r2_vld;
   logic [ADDR_W:0]   r2_idx;
   logic              launch, hit;
   logic [PAIR_W-1:0] merged;

   assign launch = (slot == SLOT_RD) && !rd_sel_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_beat <= 1'b0;
         r2_vld <= 1'b0;
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         if (q_vld && !q_beat) begin
            q_beat <= 1'b1;
         end else begin
            q_vld  <= launch;
            q_beat <= 1'b0;
         end
         r2_vld <= q_vld;
         rvalid <= r2_vld;
         if (r2_vld) rdata <= merged;
      end
   end

   always_ff @(posedge clk) begin
      if (launch && !(q_vld && !q_beat)) q_addr <= addr;
      r2_idx <= {q_addr, q_beat};
   end

   assign arr_ridx = r2_idx;
   assign hit      = cm_vld && (cm_idx == r2_idx);

   // A store landing at the same edge as the sample is forwarded lane by lane.
   for (genvar l = 0; l < LANES; l++) begin : g_fwd
      assign merged[l*BYTE_W +: BYTE_W] = (hit && cm_be[l]) ? cm_data[l*BYTE_W +: BYTE_W]
                                                            : arr_rdata[l*BYTE_W +: BYTE_W];
   end

   assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && !q_beat) |-> ##2 rvalid);

   assert_rd_two_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid);

   assert_rd_slot_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_vld && !q_beat) |-> ($past(slot) == SLOT_RD));

   assert_rd_forward_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (r2_vld && cm_vld && cm_idx == r2_idx && (&cm_be)) |=> (rdata == $past(cm_data)));
endmodule

// File: rtl/qdr_burst4_sram.sv
module qdr_burst4_sram
   import qdr_burst_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 18,
   parameter int BYTE_W = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_sel_n,
   input  logic                         wr_sel_n,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [2*WORD_W-1:0]          wdata,
   input  logic [2*WORD_W/BYTE_W-1:0]   wbe_n,
   output logic [2*WORD_W-1:0]          rdata,
   output logic                         rvalid
);
   localparam int PAIR_W = 2 * WORD_W;
   localparam int LANES  = PAIR_W / BYTE_W;
   localparam int IDX_W  = ADDR_W + 1;

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("qdr_burst4_sram: ADDR_W out of range");
   end
   if (BYTE_W < 1 || WORD_W % BYTE_W != 0) begin : g_bad_lane
      $error("qdr_burst4_sram: WORD_W must be a multiple of BYTE_W");
   end

   slot_e             slot;
   logic              cm_vld;
   logic [IDX_W-1:0]  cm_idx;
   logic [PAIR_W-1:0] cm_data;
   logic [LANES-1:0]  cm_be;
   logic [IDX_W-1:0]  arr_ridx;
   logic [PAIR_W-1:0] arr_rdata;

   qdr_slot_phase u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   qdr_write_path #(.ADDR_W(ADDR_W), .PAIR_W(PAIR_W), .LANES(LANES)) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot),
      .wr_sel_n (wr_sel_n),
      .addr     (addr),
      .wdata    (wdata),
      .wbe_n    (wbe_n),
      .cm_vld   (cm_vld),
      .cm_idx   (cm_idx),
      .cm_data  (cm_data),
      .cm_be    (cm_be)
   );

   qdr_pair_array #(.IDX_W(IDX_W), .PAIR_W(PAIR_W), .BYTE_W(BYTE_W)) u_arr (
      .clk   (clk),
      .we    (cm_vld),
      .widx  (cm_idx),
      .wdata (cm_data),
      .wbe   (cm_be),
      .ridx  (arr_ridx),
      .rdata (arr_rdata)
   );

   qdr_read_path #(.ADDR_W(ADDR_W), .PAIR_W(PAIR_W), .BYTE_W(BYTE_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot      (slot),
      .rd_sel_n  (rd_sel_n),
      .addr      (addr),
      .cm_vld    (cm_vld),
      .cm_idx    (cm_idx),
      .cm_data   (cm_data),
      .cm_be     (cm_be),
      .arr_rdata (arr_rdata),
      .arr_ridx  (arr_ridx),
      .rdata     (rdata),
      .rvalid    (rvalid)
   );
endmodule

// File: tb/qdr_burst4_sram_tb.sv
`timescale 1ns/1ps
module qdr_burst4_sram_tb;
   localparam int AW = 6;
   localparam int NP = 2 << AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_sel_n = 1'b1, wr_sel_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [35:0] wdata = '0;
   logic [3:0]  wbe_n = 4'hF;
   logic [35:0] rdata;
   logic        rvalid;

   always #2 clk = ~clk;

   qdr_burst4_sram #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
      .addr(addr), .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid)
   );

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit    chk_en = 0;

   // ---------------- behavioural reference model ----------------
   logic [35:0] mpair [NP];
   bit          m_phase = 0;   // slot of the next edge: 0 read, 1 write
   int          cyc = 0;
   bit          cv [4];
   int          cix [4];
   logic [35:0] cd [4];
   logic [3:0]  cb [4];
   bit          rv [4];
   int          rix [4];
   bit          pend = 0;
   int          paddr = 0;
   bit          exp_v = 0;
   logic [35:0] exp_d = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; pend = 0; exp_v = 0; exp_d = '0;
         for (int i = 0; i < 4; i++) begin cv[i] = 0; rv[i] = 0; end
      end else begin
         int s;
         s = cyc % 4;
         if (cv[s]) begin
            for (int l = 0; l < 4; l++)
               if (cb[s][l]) mpair[cix[s]][l*9 +: 9] = cd[s][l*9 +: 9];
            cv[s] = 0;
         end
         if (rv[s]) begin exp_v = 1; exp_d = mpair[rix[s]]; rv[s] = 0; end
         else exp_v = 0;
         if (m_phase == 0 && !rd_sel_n) begin
            rv[(cyc+2)%4] = 1; rix[(cyc+2)%4] = int'(addr) * 2;
            rv[(cyc+3)%4] = 1; rix[(cyc+3)%4] = int'(addr) * 2 + 1;
         end
         if (pend) begin
            cv[(cyc+1)%4] = 1; cix[(cyc+1)%4] = paddr * 2 + 1;
            cd[(cyc+1)%4] = wdata; cb[(cyc+1)%4] = ~wbe_n; pend = 0;
         end else if (m_phase == 1 && !wr_sel_n) begin
            cv[(cyc+1)%4] = 1; cix[(cyc+1)%4] = int'(addr) * 2;
            cd[(cyc+1)%4] = wdata; cb[(cyc+1)%4] = ~wbe_n;
            pend = 1; paddr = int'(addr);
         end
         m_phase = ~m_phase;
         cyc++;
      end
   end

   // ---------------- comparison away from the active edge ----------------
   always @(negedge clk) begin
      if (chk_en && rst_n) begin
         n_chk++;
         if (rvalid !== exp_v) begin
            n_fail++;
            $display("FAIL %s rvalid act=%0b exp=%0b cyc=%0d", cur_req, rvalid, exp_v, cyc);
         end
         if (exp_v) begin
            n_chk++;
            if (rdata !== exp_d) begin
               n_fail++;
               $display("FAIL %s rdata act=%h exp=%h cyc=%0d", cur_req, rdata, exp_d, cyc);
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step(input logic rn, input logic wn, input logic [AW-1:0] a,
                       input logic [35:0] d, input logic [3:0] ben);
      rd_sel_n = rn; wr_sel_n = wn; addr = a; wdata = d; wbe_n = ben;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1, 1, '0, '0, 4'hF);
   endtask

   task automatic wait_slot(input bit s);
      while (m_phase != s) idle(1);
   endtask

   function automatic logic [35:0] pat(input int a, input int b, input int salt);
      return 36'(a * 40503 + b * 977 + salt * 2654435) ^ 36'h5A5A5A5A5;
   endfunction

   task automatic rd(input int a);
      wait_slot(0);
      step(0, 1, AW'(a), '0, 4'hF);
   endtask

   task automatic wr(input int a, input logic [35:0] p0, input logic [3:0] b0,
                     input logic [35:0] p1, input logic [3:0] b1);
      wait_slot(1);
      step(1, 0, AW'(a), p0, b0);
      step(1, 1, AW'(a), p1, b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NP; i++) mpair[i] = '0;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero during reset
      chk(rvalid === 1'b0, "R1 rvalid in reset", {35'd0, rvalid}, '0);
      chk(rdata === '0, "R1 rdata in reset", rdata, '0);
      rst_n = 1'b1;
      chk_en = 1;
      cur_req = "R1";
      idle(4);

      // Preload every burst with full lane enables (R3)
      cur_req = "R3";
      for (int a = 0; a < (1 << AW); a++)
         wr(a, pat(a, 0, 1), 4'h0, pat(a, 1, 1), 4'h0);
      idle(2);

      // R5 / R3: single reads, isolated
      cur_req = "R5";
      rd(3); idle(6);
      rd(0); idle(6);
      rd((1 << AW) - 1); idle(6);

      // R4: partial lane enables in each beat
      cur_req = "R4";
      wr(5, 36'hFFFFFFFFF, 4'b1010, 36'h000000000, 4'b0110);
      idle(2);
      rd(5); idle(6);
      wr(9, 36'h123456789, 4'b1111, 36'hABCDEF012, 4'b0000);
      idle(2);
      rd(9); idle(6);

      // R2: selects in the wrong slot are ignored
      cur_req = "R2";
      wait_slot(1);
      step(0, 1, AW'(7), '0, 4'hF);   // read select in write slot
      idle(6);
      wait_slot(0);
      step(1, 0, AW'(7), 36'hDEADBEEF0, 4'h0);   // write select in read slot
      step(1, 1, AW'(7), 36'hDEADBEEF1, 4'h0);
      idle(2);
      rd(7); idle(6);

      // R6: a read in every read slot, writes to other bursts in between
      cur_req = "R6";
      wait_slot(0);
      for (int i = 0; i < 8; i++) begin
         step(0, 1, AW'(16 + i), (i == 0) ? 36'h0 : pat(40 + i - 1, 1, 3), 4'h0);
         step(1, 0, AW'(40 + i), pat(40 + i, 0, 3), 4'h0);
      end
      step(1, 1, '0, pat(47, 1, 3), 4'h0);
      idle(6);
      for (int i = 0; i < 3; i++) begin rd(40 + i * 3); idle(1); end
      idle(6);

      // R7: write to the same burst in the slot right after the read
      cur_req = "R7";
      wait_slot(0);
      step(0, 1, AW'(11), '0, 4'hF);
      step(1, 0, AW'(11), 36'h111122223, 4'b0000);
      step(1, 1, AW'(11), 36'h444455556, 4'b0101);
      idle(6);
      rd(11); idle(6);

      // R8: read right after a write to the same burst
      cur_req = "R8";
      wait_slot(1);
      step(1, 0, AW'(12), 36'h0F0F0F0F0, 4'h0);
      step(0, 1, AW'(12), 36'h987654321, 4'b1001);
      idle(6);

      // R9: reset keeps memory, first slot afterwards is a read
      cur_req = "R9";
      wr(20, pat(20, 0, 9), 4'h0, pat(20, 1, 9), 4'h0);
      idle(6);
      rst_n = 1'b0;
      #1;
      chk(rvalid === 1'b0, "R9 rvalid cleared by reset", {35'd0, rvalid}, '0);
      chk(rdata === '0, "R9 rdata cleared by reset", rdata, '0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1 R9";
      step(0, 1, AW'(20), '0, 4'hF);   // first slot after reset
      idle(6);
      rd(5); idle(6);

      chk_en = 0;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule